// File: doc/BRIEF.md
# Sum of Absolute Differences Engine

This block compares two blocks of unsigned byte samples and reports how far apart they are. It is idle until a one-cycle start request arrives. It then walks a shared index from 0 up to the last element and reads one byte from each of two external sample stores on every cycle. Both stores answer combinationally. For each pair it takes the magnitude of the difference and adds it to a running total. Once every pair has been consumed, the total is copied into a registered result and a one-cycle completion strobe is raised. The engine then clears itself and waits for the next start.

The result register keeps its value across idle periods and across the whole of a later run. It changes only at the instant a run finishes. The magnitude is formed by subtracting the smaller byte from the larger one, so no signed arithmetic is involved. The accumulator is sized so that the largest possible total cannot wrap. The element count, sample width and result width are parameters.

Top module: `sad_engine`

## Requirements
- R1: While reset is asserted and directly after it, `sad` is 0, `done` is 0 and `idx` is 0.
- R2: While idle with `go` low, the engine stays idle: `idx` stays 0, `done` stays 0 and `sad` keeps its value.
- R3: If `go` is high at a rising edge while idle, `idx` presents 0 in the following cycle and then advances by one each cycle up to DEPTH-1. `idx` is 0 whenever the engine is idle.
- R4: At the end of a run, `sad` equals the sum over all DEPTH element positions of the absolute difference of the two unsigned bytes. The difference is the larger byte minus the smaller one, so swapping the two stores gives the same total.
- R5: `done` is high for exactly one cycle per run. It rises at the (DEPTH+1)-th rising edge after the edge that sampled `go`.
- R6: `sad` changes only at the edge where `done` rises. It holds its value while idle and throughout the next run.
- R7: The total never wraps. With default parameters the largest total, 255 × 256 = 65280, appears zero-extended on the 32-bit `sad`.
- R8: Every run starts from a zero total, so a run's result does not depend on earlier runs.
- R9: `go` is ignored while a run is in progress. Pulsing it mid-run changes neither the result nor the completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request, sampled while idle |
| a_data | input | DW (8) | Byte from the first store at `idx` |
| b_data | input | DW (8) | Byte from the second store at `idx` |
| idx | output | log2(DEPTH) (8) | Shared element index to both stores |
| sad | output | OW (32) | Registered sum of absolute differences |
| done | output | 1 | One-cycle strobe when `sad` is updated |

## Verification
The bench builds the engine with the default DEPTH = 256, DW = 8 and OW = 32. Each run therefore makes the full walk over the 8-bit index, including the point where the 9-bit counter reaches 256 while `idx` wraps to 0. Stores filled with all 255 against all 0, and the reverse, drive the total to its ceiling of 65280 in both subtraction directions. Ramps, a hashed pattern and equal data cover the ordinary sums and the zero total. A mid-run `go` pulse and long idle stretches show that the result is independent of earlier runs and holds its value between completions.

// File: rtl/sad_engine.sv
module sad_engine #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int OW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [DW-1:0]            a_data,
  input  logic [DW-1:0]            b_data,
  output logic [$clog2(DEPTH)-1:0] idx,
  output logic [OW-1:0]            sad,
  output logic                     done
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int SW = DW + AW;

  logic          busy;
  logic [CW-1:0] cnt;
  logic [SW-1:0] sum;
  logic [DW-1:0] diff;
  logic          last;

  assign diff = (a_data >= b_data) ? (a_data - b_data) : (b_data - a_data);
  assign last = (cnt == CW'(DEPTH));
  assign idx  = cnt[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      sum  <= '0;
      sad  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sum <= '0;
        cnt <= '0;
        if (go) busy <= 1'b1;
      end else if (!last) begin
        sum <= sum + SW'(diff);
        cnt <= cnt + 1'b1;
      end else begin
        sad  <= OW'(sum);
        done <= 1'b1;
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sad_engine_chk.sv
module sad_engine_chk #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int OW    = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     go,
  input logic                     busy,
  input logic [$clog2(DEPTH)-1:0] idx,
  input logic [OW-1:0]            sad,
  input logic                     done
);
  localparam logic [OW-1:0] MAX_SAD = OW'(((2**DW) - 1) * DEPTH);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (sad == '0 && !done)); // R1
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !go) |=> (!busy && !done)); // R2
  AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (!busy && go) |=> busy); // R3
  AST_IDLE_IDX: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> idx == '0); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy) && idx != '0) |-> idx == $past(idx) + 1'b1); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R5
  AST_SAD_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sad) |-> done); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) sad <= MAX_SAD); // R7
endmodule

bind sad_engine sad_engine_chk #(.DEPTH(DEPTH), .DW(DW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .idx(idx), .sad(sad), .done(done)
);

// File: tb/sad_engine_bench.sv
module sad_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          go = 1'b0;
  logic [7:0]    a_data, b_data;
  logic [AW-1:0] idx;
  logic [31:0]   sad;
  logic          done;

  logic [7:0]  mem_a [DEPTH];
  logic [7:0]  mem_b [DEPTH];
  logic [31:0] exp_q [$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign a_data = mem_a[idx];
  assign b_data = mem_b[idx];

  sad_engine u_sad_engine (
    .clk(clk), .rst_n(rst_n), .go(go), .a_data(a_data), .b_data(b_data),
    .idx(idx), .sad(sad), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        report();
      end
    end
  end

  // monitor: pops expected totals as completions appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected done", 1, 0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(sad == e, "R4/R7/R8 sad total", sad, e);
        end
      end
    end
  end

  function automatic void fill(input int pat);
    for (int i = 0; i < DEPTH; i++) begin
      case (pat)
        0: begin mem_a[i] = 8'd0;   mem_b[i] = 8'd0;   end
        1: begin mem_a[i] = 8'd255; mem_b[i] = 8'd0;   end
        2: begin mem_a[i] = 8'd0;   mem_b[i] = 8'd255; end
        3: begin mem_a[i] = 8'(i);  mem_b[i] = 8'(255 - i); end
        4: begin mem_a[i] = 8'(i);  mem_b[i] = 8'(i);  end
        5: begin mem_a[i] = 8'(i * 37 + 11); mem_b[i] = 8'(i * 91 + 3); end
        default: begin mem_a[i] = 8'(i); mem_b[i] = 8'd0; end
      endcase
    end
  endfunction

  function automatic logic [31:0] model();
    logic [31:0] s = 0;
    for (int i = 0; i < DEPTH; i++)
      s += (mem_a[i] > mem_b[i]) ? 32'(mem_a[i] - mem_b[i]) : 32'(mem_b[i] - mem_a[i]);
    return s;
  endfunction

  // driver: loads stores, queues the expected total, starts a run
  task automatic run_case(input int pat, input bit poke_go);
    logic [31:0] prev;
    int k;
    bit idx_ok;
    fill(pat);
    exp_q.push_back(model());
    prev = sad;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    k = 0;
    idx_ok = 1'b1;
    while (!done && k < DEPTH + 10) begin
      if (k < DEPTH && idx != AW'(k)) idx_ok = 1'b0;
      if (k == 100) begin
        check(sad == prev, "R6 sad held during run", sad, prev);
        if (poke_go) go = 1'b1;
      end
      if (k == 101) go = 1'b0;
      @(negedge clk);
      k++;
    end
    check(idx_ok, "R3 idx walk", idx_ok, 1);
    check(k == DEPTH + 1, poke_go ? "R9 latency with mid-run go" : "R5 latency", k, DEPTH + 1);
    @(negedge clk);
    check(!done, "R5 done single cycle", done, 0);
    check(idx == '0, "R3 idx idle", idx, 0);
  endtask

  initial begin
    logic [31:0] held;
    fill(0);
    repeat (3) @(negedge clk);
    check(sad == 0 && !done && idx == 0, "R1 reset state", sad, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sad == 0 && !done && idx == 0, "R1 after reset", sad, 0);

    repeat (20) @(negedge clk) begin
      if (done || idx != 0) check(1'b0, "R2 idle activity", idx, 0);
    end
    check(!done && sad == 0, "R2 idle without go", sad, 0);

    run_case(1, 1'b0);   // 65280, R7 ceiling
    run_case(2, 1'b0);   // reverse direction, R4
    run_case(0, 1'b0);   // zero after max, R8
    run_case(3, 1'b0);
    run_case(5, 1'b1);   // mid-run go, R9
    run_case(4, 1'b0);
    run_case(6, 1'b0);

    held = sad;
    repeat (30) @(negedge clk);
    check(sad == held, "R6 sad held while idle", sad, held);
    check(sad == 32'd32640, "R4 ramp total", sad, 32640);
    check(exp_q.size() == 0, "R5 every run completed", exp_q.size(), 0);
    report();
  end
endmodule